// File: doc/BRIEF.md
# Data-Strobe Receive Deserializer

This block turns a two-wire data/strobe serial stream into bytes. No clock is carried on the line. A bit boundary exists wherever exactly one of the two wires has changed level, and the bit value is the data level after that change. The receiver samples both wires with a free-running local clock that runs at least three times the bit rate. It passes them through synchronisers and compares each sample with the one before it. A change on both wires within the same sample is a coding violation: it is reported as a one-cycle error pulse.

Recovered bits are packed into bytes least significant bit first. A one-cycle valid pulse is raised with each complete byte. An external alignment pulse, driven by a sync-code detector outside this block, restarts the byte boundary. After a coding violation the partial byte is discarded. The framer then stays in its fault state and ignores all bits until the next alignment pulse. A line-idle output reports a data wire that has rested high with no transitions on either wire for a set number of samples.

The framer state machine has two states. RECV assembles bits. FAULT discards bits. The transitions are:
- RECV to FAULT on a coding error.
- FAULT to RECV on an alignment pulse that does not coincide with a coding error.
- FAULT to FAULT on further errors.
- RECV to RECV on alignment, which clears the bit count.

Top module: `dstrobe_deser`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, `rx_valid`, `code_err_p` and `line_idle` are 0. The framer starts in RECV with a bit count of 0.
- R2: A bit is recognised whenever exactly one of `line_d`/`line_s` changes between two consecutive synchronised samples. Its value is the `line_d` level after the change. This holds both when data toggles and when data holds and strobe toggles.
- R3: When `line_d` and `line_s` both change in the same synchronised sample, `code_err_p` pulses high for one cycle and no bit is recognised from that sample.
- R4: Eight recognised bits form one byte. The first received bit goes to `rx_byte[0]` and the eighth to `rx_byte[7]`. `rx_valid` is a single-cycle pulse, and `rx_byte` holds that byte while it is high.
- R5: A line with no transitions produces no bits. `line_idle` goes to 1 once both wires have been quiet for `IDLE_LIMIT` samples with `line_d` high. It stays 0 while `line_d` rests low, and it drops back to 0 on the next transition.
- R6: After a coding error the partial byte is dropped. Every following bit is ignored, and no `rx_valid` is produced, until `align_p` is seen.
- R7: An `align_p` pulse clears the bit count. The next recognised bit becomes bit 0 of a new byte, and any bits received before it are discarded.
- R8: Bytes are recovered correctly when each bit is held for only three local clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_d | input | 1 | Data wire level (asynchronous) |
| line_s | input | 1 | Strobe wire level (asynchronous) |
| align_p | input | 1 | Byte alignment pulse, local clock domain |
| rx_byte | output | BYTE_W | Last assembled byte |
| rx_valid | output | 1 | One-cycle pulse with each new byte |
| code_err_p | output | 1 | One-cycle pulse on a simultaneous change of both wires |
| line_idle | output | 1 | Data high with no transitions for IDLE_LIMIT samples |

## Verification
The bench builds the block with its defaults: two synchroniser stages, 8-bit bytes and an idle limit of 16 samples. The short idle limit puts both idle polarities within a few dozen cycles. All 256 byte values are streamed twice: once ascending at four samples per bit and once descending at the three-sample minimum. This covers every data/strobe toggle pattern across byte boundaries. Directed sequences then inject a both-wire change in the middle of a byte, feed bits while in the fault state, and realign part-way through a byte. Each expected byte is computed by the bench's own encoder.

// File: rtl/dstrobe_pkg.sv
package dstrobe_pkg;

    // Framer states: assembling bits, or discarding them after a coding error
    typedef enum logic [0:0] {
        FR_RECV  = 1'b0,
        FR_FAULT = 1'b1
    } fr_state_e;

endpackage

// File: rtl/dstrobe_sync.sv
module dstrobe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/dstrobe_slot.sv
module dstrobe_slot #(
    parameter int   IDLE_LIMIT = 16,
    parameter logic D_RST      = 1'b1,
    parameter logic S_RST      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_s,
    input  logic s_s,
    output logic bit_evt,
    output logic bit_val,
    output logic code_err,
    output logic line_idle
);

    localparam int QW = $clog2(IDLE_LIMIT + 1);
    localparam logic [QW-1:0] QMAX = QW'(IDLE_LIMIT);

    logic          d_prev;
    logic          s_prev;
    logic          d_chg;
    logic          s_chg;
    logic [QW-1:0] quiet;

    assign d_chg = d_s ^ d_prev;
    assign s_chg = s_s ^ s_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_prev    <= D_RST;
            s_prev    <= S_RST;
            bit_evt   <= 1'b0;
            bit_val   <= 1'b0;
            code_err  <= 1'b0;
            quiet     <= '0;
            line_idle <= 1'b0;
        end else begin
            d_prev   <= d_s;
            s_prev   <= s_s;
            bit_evt  <= d_chg ^ s_chg;
            bit_val  <= d_s;
            code_err <= d_chg & s_chg;
            if (d_chg | s_chg) begin
                quiet <= '0;
            end else if (quiet != QMAX) begin
                quiet <= quiet + 1'b1;
            end
            line_idle <= (quiet == QMAX) && d_s && !(d_chg | s_chg);
        end
    end

endmodule

// File: rtl/dstrobe_framer.sv
module dstrobe_framer
    import dstrobe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  logic              code_err,
    input  logic              align,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    fr_state_e         state;
    fr_state_e         state_nx;
    logic [CW-1:0]     bit_cnt;
    logic [BYTE_W-1:0] shreg;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_RECV:  if (code_err) state_nx = FR_FAULT;
            FR_FAULT: if (!code_err && align) state_nx = FR_RECV;
            default:  state_nx = FR_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_RECV;
        else        state <= state_nx;
    end

    // output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                FR_RECV: begin
                    if (code_err || align) begin
                        bit_cnt <= '0;
                        shreg   <= '0;
                    end else if (bit_evt) begin
                        shreg <= {bit_val, shreg[BYTE_W-1:1]};
                        if (bit_cnt == LAST) begin
                            rx_byte  <= {bit_val, shreg[BYTE_W-1:1]};
                            rx_valid <= 1'b1;
                            bit_cnt  <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                FR_FAULT: begin
                    if (!code_err && align) begin
                        bit_cnt <= '0;
                        shreg   <= '0;
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    AST_ERR_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> (state == FR_FAULT)); // R6

    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_FAULT) |=> !rx_valid); // R6

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4

    AST_ALIGN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (align && !code_err) |=> (bit_cnt == '0)); // R7

endmodule

// File: rtl/dstrobe_deser.sv
module dstrobe_deser #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int IDLE_LIMIT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_d,
    input  logic              line_s,
    input  logic              align_p,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              code_err_p,
    output logic              line_idle
);

    logic d_s;
    logic s_s;
    logic bit_evt;
    logic bit_val;

    dstrobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_d (
        .clk(clk), .rst_n(rst_n), .d_in(line_d), .d_out(d_s)
    );

    dstrobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_s (
        .clk(clk), .rst_n(rst_n), .d_in(line_s), .d_out(s_s)
    );

    dstrobe_slot #(.IDLE_LIMIT(IDLE_LIMIT), .D_RST(1'b1), .S_RST(1'b0)) u_slot (
        .clk(clk), .rst_n(rst_n), .d_s(d_s), .s_s(s_s),
        .bit_evt(bit_evt), .bit_val(bit_val), .code_err(code_err_p),
        .line_idle(line_idle)
    );

    dstrobe_framer #(.BYTE_W(BYTE_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_val(bit_val),
        .code_err(code_err_p), .align(align_p),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        line_idle |-> !rx_valid); // R5

endmodule

// File: tb/dstrobe_deser_bench.sv
module dstrobe_deser_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_d = 1'b1;
    logic       line_s = 1'b0;
    logic       align_p = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       code_err_p;
    logic       line_idle;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    int err_cnt = 0;
    logic cur_d = 1'b1;
    logic cur_s = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    dstrobe_deser u_dstrobe_deser (
        .clk(clk), .rst_n(rst_n), .line_d(line_d), .line_s(line_s),
        .align_p(align_p), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .code_err_p(code_err_p), .line_idle(line_idle)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // byte monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R7 unexpected byte", rx_byte, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_byte == e, "R2/R4 byte value", rx_byte, e);
            end
        end
        if (rst_n && code_err_p) err_cnt++;
    end

    task automatic send_bit(input logic b, input int hold);
        if (b != cur_d) cur_d = b;
        else            cur_s = ~cur_s;
        @(negedge clk);
        line_d = cur_d;
        line_s = cur_s;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int hold, input logic expect_it);
        if (expect_it) exp_q.push_back(v);
        for (int i = 0; i < 8; i++) send_bit(v[i], hold);
    endtask

    task automatic pulse_align();
        repeat (6) @(negedge clk);
        align_p = 1'b1;
        @(negedge clk);
        align_p = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int e0;
        repeat (4) @(negedge clk);
        check(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
        check(code_err_p == 1'b0, "R1 reset code_err_p", code_err_p, 0);
        check(line_idle == 1'b0, "R1 reset line_idle", line_idle, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rx_valid == 1'b0 && code_err_p == 1'b0, "R1 after reset", rx_valid, 0);

        // R4 / R2: all byte values, four samples per bit
        for (int v = 0; v < 256; v++) send_byte(8'(v), 4, 1'b1);
        repeat (10) @(negedge clk);
        check(rx_cnt == 256, "R4 byte count ascending sweep", rx_cnt, 256);
        check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);

        // R8: all values descending, minimum three samples per bit
        for (int v = 255; v >= 0; v--) send_byte(8'(v), 3, 1'b1);
        repeat (10) @(negedge clk);
        check(rx_cnt == 512, "R8 byte count at 3x oversampling", rx_cnt, 512);
        check(err_cnt == 0, "R3 no error on clean stream", err_cnt, 0);

        // R5: line rests low (last bit was 0): no idle indication
        repeat (40) @(negedge clk);
        check(line_idle == 1'b0, "R5 data low is not idle", line_idle, 0);
        base = rx_cnt;
        send_bit(1'b1, 4);
        repeat (40) @(negedge clk);
        check(line_idle == 1'b1, "R5 quiet high line is idle", line_idle, 1);
        check(rx_cnt == base, "R5 no bytes while idle", rx_cnt, base);
        send_bit(1'b0, 4);
        check(line_idle == 1'b0, "R5 idle drops on transition", line_idle, 0);

        // R3 / R6: error in the middle of a byte
        pulse_align();
        base = rx_cnt;
        e0 = err_cnt;
        send_bit(1'b1, 4);
        send_bit(1'b0, 4);
        send_bit(1'b0, 4);
        cur_d = ~cur_d;
        cur_s = ~cur_s;
        @(negedge clk);
        line_d = cur_d;
        line_s = cur_s;
        repeat (5) @(negedge clk);
        check(err_cnt == e0 + 1, "R3 single error pulse", err_cnt, e0 + 1);
        for (int i = 0; i < 13; i++) send_bit(i[0], 4);
        repeat (8) @(negedge clk);
        check(rx_cnt == base, "R6 bits ignored after error", rx_cnt, base);
        pulse_align();
        send_byte(8'hA5, 4, 1'b1);
        repeat (8) @(negedge clk);
        check(rx_cnt == base + 1, "R6 recovery after align", rx_cnt, base + 1);

        // R7: align mid-byte discards partial bits
        base = rx_cnt;
        for (int i = 0; i < 5; i++) send_bit(1'b1, 4);
        pulse_align();
        send_byte(8'h3C, 4, 1'b1);
        send_byte(8'hC3, 3, 1'b1);
        repeat (8) @(negedge clk);
        check(rx_cnt == base + 2, "R7 realigned byte count", rx_cnt, base + 2);
        check(exp_q.size() == 0, "R7 all expected bytes seen", exp_q.size(), 0);

        finish_run();
    end

endmodule